// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address stream for a synchronous memory that takes a single starting address and then walks through a short burst on its own. On every cycle where the clock enable is high, the `adv` control picks one of two actions. Low captures a fresh external address as the first beat of a new burst. High steps an internal beat counter. The low address bits follow one of two beat orders. In linear order they wrap by addition. In interleaved order they are the start bits XORed with the beat index. The order is chosen by a mode pin that is captured together with the address. The upper bits keep their loaded value for the whole burst, because the wrap never carries into them.

The output address, a beat index and a valid flag come straight from registers through one level of adder or XOR logic, so every command takes effect on the edge at which it is sampled. A new burst can start on the cycle right after any other command, so bursts run back to back with no gap. There is no back-pressure path. The consumer pauses the sequence by driving `ce` low, which freezes all state. The width of the beat counter is a parameter, and the default of two bits gives four beats.

Top module: `burst_addr_seq`

## Requirements
- R1: With `ce`=1 and `adv`=0 at a rising edge, after that edge `addr_o` equals `ext_addr`, `beat_o` is 0 and `valid_o` is 1.
- R2: With `ce`=1 and `adv`=1 at a rising edge, `beat_o` increases by one modulo four after that edge, and `valid_o` becomes 1.
- R3: If `ilv_mode` was 0 at the last load, `addr_o[1:0]` equals (start + beat) mod 4. A start of 2 gives 2, 3, 0, 1.
- R4: If `ilv_mode` was 1 at the last load, `addr_o[1:0]` equals start XOR beat. A start of 1 gives 1, 0, 3, 2.
- R5: After the fourth beat, a further advance returns to the loaded address, and the four addresses repeat for as long as advance continues. `addr_o[AW-1:2]` never changes on an advance.
- R6: `ilv_mode` is sampled only on a load cycle. Changing it while advancing does not alter the remaining beats.
- R7: An advance with no load since reset steps in linear order from address 0, giving 1, 2, 3, 0, and so on.
- R8: With `rst`=1 at a rising edge, after that edge `addr_o` is 0, `beat_o` is 0 and `valid_o` is 0, whatever `ce` is.
- R9: With `ce`=0 at a rising edge, `addr_o`, `beat_o` and `valid_o` keep their values, whatever `adv`, `ext_addr` and `ilv_mode` are.
- R10: A load directly after a load or after an advance takes effect on its own edge, with no idle cycle inserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; low freezes all state |
| adv | input | 1 | 0 = load `ext_addr`, 1 = advance the burst |
| ilv_mode | input | 1 | Beat order taken at load: 0 linear, 1 interleaved |
| ext_addr | input | AW | Starting address for a new burst |
| addr_o | output | AW | Current access address |
| beat_o | output | 2 | Beat index within the current burst |
| valid_o | output | 1 | High once any enabled cycle has occurred since reset |

## Verification
Every output is due exactly one rising edge after the command that produced it, and it then stays put until the next enabled edge. The bench drives inputs on the falling edge. It updates its behavioural model at the following rising edge and compares all three outputs on the falling edge after that. This puts each comparison half a cycle away from any edge at which the design changes. Explicit beat-by-beat lists for the order, wrap, mode-capture and first-advance cases are checked at the same point, on top of the per-cycle model comparison.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } order_e;
endpackage

// File: rtl/bseq_base_reg.sv
module bseq_base_reg
  import bseq_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  input  logic          mode_in,
  output logic [AW-1:0] base_q,
  output order_e        mode_q,
  output logic          valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      mode_q  <= ORD_LINEAR;
      valid_q <= 1'b0;
    end else if (ce) begin
      valid_q <= 1'b1;
      if (load) begin
        base_q <= addr_in;
        mode_q <= order_e'(mode_in);
      end
    end
  end

  // base and order only move on a load
  assert_base_fixed_R5: assert property (@(posedge clk) disable iff (rst)
    (!load || !ce) |=> ($stable(base_q) && $stable(mode_q)));
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          load,
  output logic [BW-1:0] beat_q
);
  always_ff @(posedge clk) begin
    if (rst)       beat_q <= '0;
    else if (ce) begin
      if (load)    beat_q <= '0;
      else         beat_q <= beat_q + 1'b1;
    end
  end

  assert_load_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (ce && load) |=> (beat_q == '0));
endmodule

// File: rtl/bseq_order.sv
module bseq_order
  import bseq_pkg::*;
#(
  parameter int BW = 2
) (
  input  logic [BW-1:0] start,
  input  logic [BW-1:0] beat,
  input  order_e        mode,
  output logic [BW-1:0] low
);
  always_comb begin
    unique case (mode)
      ORD_INTERLEAVED: low = start ^ beat;
      default:         low = start + beat;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int AW = 20,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          adv,
  input  logic          ilv_mode,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] addr_o,
  output logic [BW-1:0] beat_o,
  output logic          valid_o
);
  localparam int HI_W = AW - BW;

  logic [AW-1:0] base_q;
  order_e        mode_q;
  logic [BW-1:0] low_bits;
  logic          load;

  assign load = ~adv;

  bseq_base_reg #(.AW(AW)) u_base (
    .clk(clk), .rst(rst), .ce(ce), .load(load),
    .addr_in(ext_addr), .mode_in(ilv_mode),
    .base_q(base_q), .mode_q(mode_q), .valid_q(valid_o)
  );

  bseq_beat_ctr #(.BW(BW)) u_ctr (
    .clk(clk), .rst(rst), .ce(ce), .load(load), .beat_q(beat_o)
  );

  bseq_order #(.BW(BW)) u_ord (
    .start(base_q[BW-1:0]), .beat(beat_o), .mode(mode_q), .low(low_bits)
  );

  assign addr_o = {base_q[AW-1:BW], low_bits};

  assert_load_addr_R1: assert property (@(posedge clk) disable iff (rst)
    (ce && !adv) |=> (addr_o == $past(ext_addr) && valid_o));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (ce && adv) |=> (beat_o == BW'($past(beat_o) + 1'b1) && valid_o));

  assert_linear_R3: assert property (@(posedge clk) disable iff (rst)
    (ce && adv && mode_q == ORD_LINEAR)
      |=> (addr_o[BW-1:0] == BW'($past(addr_o[BW-1:0]) + 1'b1)));

  assert_interleave_R4: assert property (@(posedge clk) disable iff (rst)
    (ce && adv && mode_q == ORD_INTERLEAVED)
      |=> ((addr_o[BW-1:0] ^ beat_o) == $past(addr_o[BW-1:0] ^ beat_o)));

  assert_upper_R5: assert property (@(posedge clk) disable iff (rst)
    (ce && adv) |=> (addr_o[AW-1:AW-HI_W] == $past(addr_o[AW-1:AW-HI_W])));

  assert_mode_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (ce && adv) |=> $stable(mode_q));

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (addr_o == '0 && beat_o == '0 && !valid_o));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(addr_o) && $stable(beat_o) && $stable(valid_o)));
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst, ce, adv, ilv_mode;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] addr_o;
  logic [1:0]    beat_o;
  logic          valid_o;

  always #5 clk = ~clk;

  burst_addr_seq #(.AW(AW), .BW(2)) u_burst_addr_seq (
    .clk(clk), .rst(rst), .ce(ce), .adv(adv), .ilv_mode(ilv_mode),
    .ext_addr(ext_addr), .addr_o(addr_o), .beat_o(beat_o), .valid_o(valid_o)
  );

  int            checks = 0;
  int            fails  = 0;
  string         tag    = "R8";
  logic [AW-1:0] m_base = '0;
  int            m_beat = 0;
  int            m_mode = 0;
  logic          m_valid = 1'b0;

  function automatic logic [AW-1:0] model_addr();
    int lo;
    if (m_mode != 0) lo = int'(m_base[1:0]) ^ m_beat;
    else             lo = (int'(m_base[1:0]) + m_beat) % 4;
    return {m_base[AW-1:2], 2'(lo)};
  endfunction

  task automatic compare();
    logic [AW-1:0] ea;
    ea = model_addr();
    checks++;
    if (addr_o !== ea || beat_o !== 2'(m_beat) || valid_o !== m_valid) begin
      fails++;
      $display("FAIL %s: addr=%h beat=%0d valid=%b expected addr=%h beat=%0d valid=%b",
               tag, addr_o, beat_o, valid_o, ea, m_beat, m_valid);
    end
  endtask

  task automatic tick(input logic r, input logic c, input logic a,
                      input logic m, input logic [AW-1:0] ad);
    rst = r; ce = c; adv = a; ilv_mode = m; ext_addr = ad;
    @(posedge clk);
    if (r) begin
      m_base = '0; m_beat = 0; m_mode = 0; m_valid = 1'b0;
    end else if (c) begin
      if (!a) begin m_base = ad; m_beat = 0; m_mode = int'(m); end
      else    m_beat = (m_beat + 1) % 4;
      m_valid = 1'b1;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic expect_lo(input int v);
    checks++;
    if (int'(addr_o[1:0]) != v) begin
      fails++;
      $display("FAIL %s: low bits=%0d expected %0d", tag, addr_o[1:0], v);
    end
  endtask

  task automatic expect_hi(input logic [AW-3:0] v);
    checks++;
    if (addr_o[AW-1:2] !== v) begin
      fails++;
      $display("FAIL %s: upper=%h expected %h", tag, addr_o[AW-1:2], v);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R8: reset state
    tag = "R8";
    tick(1, 0, 0, 0, '0);
    tick(1, 1, 0, 1, 20'hFFFFF);
    // R7: advance before any load walks from zero in linear order
    tag = "R7";
    tick(0, 1, 1, 1, 20'h55555); expect_lo(1);
    tick(0, 1, 1, 1, 20'h55555); expect_lo(2);
    tick(0, 1, 1, 0, 20'h55555); expect_lo(3);
    tick(0, 1, 1, 0, 20'h55555); expect_lo(0); expect_hi('0);
    // R1: load
    tag = "R1";
    tick(0, 1, 0, 0, 20'hABCDE); expect_lo(2); expect_hi(18'(20'hABCDE >> 2));
    // R3: linear from start 2
    tag = "R3";
    tick(0, 1, 1, 0, '0); expect_lo(3);
    tick(0, 1, 1, 0, '0); expect_lo(0);
    tick(0, 1, 1, 0, '0); expect_lo(1);
    // R5: wrap back to start, upper bits unchanged
    tag = "R5";
    tick(0, 1, 1, 0, '0); expect_lo(2); expect_hi(18'(20'hABCDE >> 2));
    for (int i = 0; i < 6; i++) tick(0, 1, 1, 0, 20'h3);
    expect_hi(18'(20'hABCDE >> 2));
    // R4: interleaved from start 1
    tag = "R4";
    tick(0, 1, 0, 1, 20'h12345); expect_lo(1);
    tick(0, 1, 1, 1, '0); expect_lo(0);
    tick(0, 1, 1, 1, '0); expect_lo(3);
    tick(0, 1, 1, 1, '0); expect_lo(2);
    tick(0, 1, 1, 1, '0); expect_lo(1);
    // R6: mode changes mid-burst are ignored
    tag = "R6";
    tick(0, 1, 0, 1, 20'h00401);
    tick(0, 1, 1, 0, '0); expect_lo(0);
    tick(0, 1, 1, 0, '0); expect_lo(3);
    tick(0, 1, 1, 0, '0); expect_lo(2);
    tick(0, 1, 0, 0, 20'h00801);
    tick(0, 1, 1, 1, '0); expect_lo(2);
    tick(0, 1, 1, 1, '0); expect_lo(3);
    tick(0, 1, 1, 1, '0); expect_lo(0);
    // R9: clock enable low holds everything
    tag = "R9";
    tick(0, 0, 0, 1, 20'hFFFFF); expect_lo(0);
    tick(0, 0, 1, 0, 20'h00000); expect_lo(0);
    tick(0, 0, 0, 0, 20'h12345); expect_hi(18'(20'h00801 >> 2));
    // R10: back-to-back loads and load right after advance
    tag = "R10";
    tick(0, 1, 0, 0, 20'h11112); expect_lo(2);
    tick(0, 1, 0, 1, 20'h22223); expect_lo(3);
    tick(0, 1, 1, 1, '0);        expect_lo(2);
    tick(0, 1, 0, 0, 20'h33330); expect_lo(0); expect_hi(18'(20'h33330 >> 2));
    // R2: mixed random traffic against the model
    tag = "R2";
    for (int i = 0; i < 300; i++)
      tick(0, ($urandom % 4) != 0, ($urandom % 3) != 0, 1'($urandom),
           AW'($urandom));
    // R8: reset in the middle of a burst
    tag = "R8";
    tick(0, 1, 0, 1, 20'hFEDC3);
    tick(1, 1, 1, 1, '0);
    tick(0, 1, 1, 1, '0); expect_lo(1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule